// File: doc/BRIEF.md
# Single-Lane Link Training Controller

This block sequences the bring-up of one serial lane from reset to a usable link. After reset it waits quietly, then asks the analog front end to probe for a far-end receiver, exchanges two kinds of training ordered sets with the partner, agrees on the link and lane identity, and finally raises a link-up flag. All training runs at the base signalling rate of 2.5 GT/s. A rate change is never requested.

The controller does not build or parse ordered sets itself. An upstream decoder reports each received set as a one-cycle event, with its kind and its link and lane number fields. The transmitter pulses `tx_done` each time it finishes sending the set the controller asks for. The quiet-phase limit (nominally 12 ms) and the training-phase limit (nominally 24 ms) are given in clock cycles, so a bench can scale them down. Encodings: `rx_kind` 0 is the first kind of training set and 1 is the second kind. The empty-field symbol is 8'hF7. The state code is 0 quiet, 1 receiver detect, 2 polling with first-kind sets, 3 polling with second-kind sets, 4 configuration, and 5 link active.

Top module: `link_train_ctrl`

## Requirements
- R1: While `rst` is high and one cycle after it falls, `ltssm_state` is 0, `det_req`, both transmit requests and `link_up` are low, and `tx_link`/`tx_lane` carry 8'hF7.
- R2: State 0 moves to state 1 on the edge where `idle_exit` is high, or after QUIET_CYCLES cycles in state 0. `det_req` is high exactly in state 1.
- R3: In state 1, `det_done` with `det_present` low returns the machine to state 0. `det_done` has no effect in any other state.
- R4: In state 1, `det_done` with `det_present` high moves to state 2. State 2 requests first-kind sets (`tx_a_req`) with both number fields at 8'hF7.
- R5: State 2 moves to state 3 once RX_NEED consecutive received sets have the same kind. A set whose kind differs from the previous one restarts the run at one. State 3 requests second-kind sets (`tx_b_req`) with both fields at 8'hF7.
- R6: State 3 moves to state 4 once RX_NEED consecutive second-kind sets are received and TX_NEED `tx_done` pulses have been counted. Counting starts only after the first second-kind set in state 3 has been received, and pulses before that are ignored.
- R7: State 4 requests second-kind sets carrying `tx_link` = LINK_ID and `tx_lane` = LANE_ID. A received set that is not second-kind with exactly those numbers resets the run of matching sets to zero.
- R8: State 4 moves to state 5 once RX_NEED consecutive matching sets are received and TX_NEED sets are sent, counted from the first match. `link_up` is high exactly in state 5.
- R9: State 5 holds until reset, and no training set is requested in it.
- R10: Spending TRAIN_CYCLES cycles in state 2, 3 or 4 returns the machine to state 0. The limit restarts on every state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_exit | input | 1 | Lane has left electrical idle |
| det_done | input | 1 | Receiver-detect probe finished (one-cycle pulse) |
| det_present | input | 1 | Probe result, 1 = far-end receiver present |
| rx_valid | input | 1 | A training set was received this cycle |
| rx_kind | input | 1 | Kind of received set: 0 first, 1 second |
| rx_link | input | 8 | Link number field of the received set |
| rx_lane | input | 8 | Lane number field of the received set |
| tx_done | input | 1 | Transmitter finished one requested set |
| det_req | output | 1 | Request a receiver-detect probe |
| tx_a_req | output | 1 | Request first-kind training sets |
| tx_b_req | output | 1 | Request second-kind training sets |
| tx_link | output | 8 | Link number field to transmit |
| tx_lane | output | 8 | Lane number field to transmit |
| ltssm_state | output | 3 | Current state code |
| link_up | output | 1 | Link is trained and active |

## Verification
Every output is decoded from the registered state, so a wrong state shows up on `ltssm_state`, the transmit requests and the number fields in the same cycle it is entered. A wrong run or sent-set count cannot be seen directly. It shows up as a state change one cycle too early or too late, after the event that should have completed the count. The bench therefore checks the state on the cycle after the last event of each burst. It places bursts one short of the threshold, bursts that break a run, and `tx_done` pulses that arrive before counting is allowed. A timer fault shows up as an early or missing return to state 0, so the bench checks shortly before and shortly after each limit.

// File: rtl/lt_pkg.sv
package lt_pkg;

    typedef enum logic [2:0] {
        ST_QUIET    = 3'd0,
        ST_DETECT   = 3'd1,
        ST_POLL_A   = 3'd2,
        ST_POLL_B   = 3'd3,
        ST_CONFIG   = 3'd4,
        ST_ACTIVE   = 3'd5
    } lt_state_e;

    typedef enum logic {
        KIND_A = 1'b0,
        KIND_B = 1'b1
    } ts_kind_e;

    typedef enum logic [1:0] {
        TRK_SAME  = 2'd0,
        TRK_KIND_B = 2'd1,
        TRK_MATCH = 2'd2,
        TRK_OFF   = 2'd3
    } trk_mode_e;

    typedef struct packed {
        logic       valid;
        ts_kind_e   kind;
        logic [7:0] link;
        logic [7:0] lane;
    } ts_event_t;

    localparam logic [7:0] PAD_SYM = 8'hF7;

    function automatic trk_mode_e mode_of(lt_state_e s);
        case (s)
            ST_POLL_A: return TRK_SAME;
            ST_POLL_B: return TRK_KIND_B;
            ST_CONFIG: return TRK_MATCH;
            default:   return TRK_OFF;
        endcase
    endfunction

    function automatic logic is_training(lt_state_e s);
        return (s == ST_POLL_A) || (s == ST_POLL_B) || (s == ST_CONFIG);
    endfunction

endpackage

// File: rtl/lt_dwell_timer.sv
module lt_dwell_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    assign expired = (cnt_q >= (limit - W'(1)));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q < limit) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // R10
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !restart |=> (cnt_q <= $past(limit)));

endmodule

// File: rtl/lt_set_tracker.sv
module lt_set_tracker
    import lt_pkg::*;
#(
    parameter int RX_NEED = 8,
    parameter int TX_NEED = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  trk_mode_e  mode,
    input  ts_event_t  ev,
    input  logic [7:0] exp_link,
    input  logic [7:0] exp_lane,
    input  logic       tx_done,
    output logic       rx_ok,
    output logic       tx_ok
);
    localparam int RCW = $clog2(RX_NEED + 1);
    localparam int TCW = $clog2(TX_NEED + 1);

    logic [RCW-1:0] rx_cnt_q, rx_bump;
    logic [TCW-1:0] tx_cnt_q;
    logic           seen_q;
    logic           have_prev_q;
    ts_kind_e       prev_kind_q;
    logic           good;

    assign rx_bump = (rx_cnt_q < RCW'(RX_NEED)) ? rx_cnt_q + RCW'(1) : rx_cnt_q;
    assign good    = (ev.kind == KIND_B) &&
                     ((mode != TRK_MATCH) || ((ev.link == exp_link) && (ev.lane == exp_lane)));
    assign rx_ok   = (rx_cnt_q >= RCW'(RX_NEED));
    assign tx_ok   = (tx_cnt_q >= TCW'(TX_NEED));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rx_cnt_q    <= '0;
            tx_cnt_q    <= '0;
            seen_q      <= 1'b0;
            have_prev_q <= 1'b0;
            prev_kind_q <= KIND_A;
        end else begin
            if (ev.valid) begin
                have_prev_q <= 1'b1;
                prev_kind_q <= ev.kind;
                case (mode)
                    TRK_SAME: begin
                        rx_cnt_q <= (have_prev_q && (ev.kind == prev_kind_q)) ? rx_bump : RCW'(1);
                    end
                    TRK_KIND_B, TRK_MATCH: begin
                        if (good) begin
                            rx_cnt_q <= rx_bump;
                            seen_q   <= 1'b1;
                        end else begin
                            rx_cnt_q <= '0;
                        end
                    end
                    default: ;
                endcase
            end
            if (seen_q && tx_done && (tx_cnt_q < TCW'(TX_NEED))) begin
                tx_cnt_q <= tx_cnt_q + TCW'(1);
            end
        end
    end

    // R6
    tx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !seen_q |-> (tx_cnt_q == '0));

    // R7
    match_break_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && ev.valid && (mode == TRK_MATCH) && !good) |=> (rx_cnt_q == '0));

endmodule

// File: rtl/link_train_ctrl.sv
module link_train_ctrl
    import lt_pkg::*;
#(
    parameter int         QUIET_CYCLES = 3_000_000,
    parameter int         TRAIN_CYCLES = 6_000_000,
    parameter int         RX_NEED      = 8,
    parameter int         TX_NEED      = 16,
    parameter logic [7:0] LINK_ID      = 8'd1,
    parameter logic [7:0] LANE_ID      = 8'd0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       idle_exit,
    input  logic       det_done,
    input  logic       det_present,
    input  logic       rx_valid,
    input  logic       rx_kind,
    input  logic [7:0] rx_link,
    input  logic [7:0] rx_lane,
    input  logic       tx_done,
    output logic       det_req,
    output logic       tx_a_req,
    output logic       tx_b_req,
    output logic [7:0] tx_link,
    output logic [7:0] tx_lane,
    output logic [2:0] ltssm_state,
    output logic       link_up
);
    localparam int MAXC = (QUIET_CYCLES > TRAIN_CYCLES) ? QUIET_CYCLES : TRAIN_CYCLES;
    localparam int TW   = $clog2(MAXC + 1);

    lt_state_e   state_q, state_d;
    ts_event_t   ev;
    logic        tmo, rx_ok, tx_ok, chg;
    logic [TW-1:0] limit;

    assign ev.valid = rx_valid;
    assign ev.kind  = ts_kind_e'(rx_kind);
    assign ev.link  = rx_link;
    assign ev.lane  = rx_lane;

    assign limit = (state_q == ST_QUIET) ? TW'(QUIET_CYCLES) : TW'(TRAIN_CYCLES);
    assign chg   = (state_d != state_q);

    lt_dwell_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (chg),
        .limit   (limit),
        .expired (tmo)
    );

    lt_set_tracker #(.RX_NEED(RX_NEED), .TX_NEED(TX_NEED)) u_track (
        .clk      (clk),
        .rst      (rst),
        .clear    (chg),
        .mode     (mode_of(state_q)),
        .ev       (ev),
        .exp_link (LINK_ID),
        .exp_lane (LANE_ID),
        .tx_done  (tx_done),
        .rx_ok    (rx_ok),
        .tx_ok    (tx_ok)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_QUIET:  if (idle_exit || tmo) state_d = ST_DETECT;
            ST_DETECT: if (det_done) state_d = det_present ? ST_POLL_A : ST_QUIET;
            ST_POLL_A: if (tmo) state_d = ST_QUIET;
                       else if (rx_ok) state_d = ST_POLL_B;
            ST_POLL_B: if (tmo) state_d = ST_QUIET;
                       else if (rx_ok && tx_ok) state_d = ST_CONFIG;
            ST_CONFIG: if (tmo) state_d = ST_QUIET;
                       else if (rx_ok && tx_ok) state_d = ST_ACTIVE;
            ST_ACTIVE: state_d = ST_ACTIVE;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_QUIET;
        else     state_q <= state_d;
    end

    assign ltssm_state = state_q;
    assign det_req     = (state_q == ST_DETECT);
    assign tx_a_req    = (state_q == ST_POLL_A);
    assign tx_b_req    = (state_q == ST_POLL_B) || (state_q == ST_CONFIG);
    assign tx_link     = (state_q == ST_CONFIG) ? LINK_ID : PAD_SYM;
    assign tx_lane     = (state_q == ST_CONFIG) ? LANE_ID : PAD_SYM;
    assign link_up     = (state_q == ST_ACTIVE);

    // R1
    reset_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ltssm_state == 3'd0));

    // R3
    det_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DETECT && det_done && !det_present) |=> (state_q == ST_QUIET));

    // R8
    up_from_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up) |-> ($past(state_q) == ST_CONFIG));

    // R9
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE) |=> (state_q == ST_ACTIVE));

    // R10
    train_tmo_chk: assert property (@(posedge clk) disable iff (rst)
        (is_training(state_q) && tmo) |=> (state_q == ST_QUIET));

endmodule

// File: tb/link_train_ctrl_bench.sv
module link_train_ctrl_bench;
    localparam int         CLK_PERIOD = 10;
    localparam int         QC = 40;
    localparam int         TC = 80;
    localparam logic [7:0] LID = 8'd5;
    localparam logic [7:0] NID = 8'd2;
    localparam logic [7:0] PAD = 8'hF7;

    localparam logic [2:0] OP_WAIT = 3'd0, OP_EXIT = 3'd1, OP_DET0 = 3'd2, OP_DET1 = 3'd3,
                           OP_RX = 3'd4, OP_TXD = 3'd5, OP_RST = 3'd6;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] cnt;
        logic       kind;
        logic [7:0] link;
        logic [7:0] lane;
        logic [2:0] exp;
        logic [3:0] req;
    } step_t;

    localparam int NSTEP = 31;
    localparam step_t STEPS [NSTEP] = '{
        '{OP_RST,  8'd2,  1'b0, PAD, PAD, 3'd0, 4'd1},   // R1
        '{OP_DET1, 8'd1,  1'b0, PAD, PAD, 3'd0, 4'd3},   // R3 ignored in quiet
        '{OP_WAIT, 8'd8,  1'b0, PAD, PAD, 3'd0, 4'd2},
        '{OP_EXIT, 8'd1,  1'b0, PAD, PAD, 3'd1, 4'd2},   // R2 idle exit
        '{OP_RX,   8'd3,  1'b1, PAD, PAD, 3'd1, 4'd3},   // R3 stays waiting
        '{OP_DET0, 8'd1,  1'b0, PAD, PAD, 3'd0, 4'd3},   // R3 absent
        '{OP_WAIT, 8'd30, 1'b0, PAD, PAD, 3'd0, 4'd2},
        '{OP_WAIT, 8'd12, 1'b0, PAD, PAD, 3'd1, 4'd2},   // R2 timeout
        '{OP_DET1, 8'd1,  1'b0, PAD, PAD, 3'd2, 4'd4},   // R4
        '{OP_RX,   8'd7,  1'b0, PAD, PAD, 3'd2, 4'd5},   // R5 one short
        '{OP_RX,   8'd1,  1'b1, PAD, PAD, 3'd2, 4'd5},   // R5 kind change restarts
        '{OP_RX,   8'd6,  1'b1, PAD, PAD, 3'd2, 4'd5},
        '{OP_RX,   8'd1,  1'b1, PAD, PAD, 3'd3, 4'd5},
        '{OP_TXD,  8'd20, 1'b0, PAD, PAD, 3'd3, 4'd6},   // R6 early sends ignored
        '{OP_RX,   8'd8,  1'b1, PAD, PAD, 3'd3, 4'd6},
        '{OP_TXD,  8'd15, 1'b0, PAD, PAD, 3'd3, 4'd6},
        '{OP_TXD,  8'd1,  1'b0, PAD, PAD, 3'd4, 4'd6},   // R6
        '{OP_RX,   8'd7,  1'b1, LID, NID, 3'd4, 4'd7},   // R7
        '{OP_TXD,  8'd16, 1'b0, PAD, PAD, 3'd4, 4'd8},
        '{OP_RX,   8'd1,  1'b1, LID, 8'd3, 3'd4, 4'd7},  // R7 mismatch resets
        '{OP_RX,   8'd7,  1'b1, LID, NID, 3'd4, 4'd7},
        '{OP_RX,   8'd1,  1'b1, LID, NID, 3'd5, 4'd8},   // R8
        '{OP_WAIT, 8'd100,1'b0, PAD, PAD, 3'd5, 4'd9},   // R9
        '{OP_RST,  8'd1,  1'b0, PAD, PAD, 3'd0, 4'd1},
        '{OP_EXIT, 8'd1,  1'b0, PAD, PAD, 3'd1, 4'd2},
        '{OP_DET1, 8'd1,  1'b0, PAD, PAD, 3'd2, 4'd4},
        '{OP_WAIT, 8'd70, 1'b0, PAD, PAD, 3'd2, 4'd10},  // R10 before limit
        '{OP_WAIT, 8'd12, 1'b0, PAD, PAD, 3'd0, 4'd10},  // R10 after limit
        '{OP_EXIT, 8'd1,  1'b0, PAD, PAD, 3'd1, 4'd2},
        '{OP_DET1, 8'd1,  1'b0, PAD, PAD, 3'd2, 4'd4},
        '{OP_RX,   8'd8,  1'b0, PAD, PAD, 3'd3, 4'd10}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic idle_exit = 0, det_done = 0, det_present = 0, rx_valid = 0, rx_kind = 0, tx_done = 0;
    logic [7:0] rx_link = PAD, rx_lane = PAD;
    logic det_req, tx_a_req, tx_b_req, link_up;
    logic [7:0] tx_link, tx_lane;
    logic [2:0] ltssm_state;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    link_train_ctrl #(
        .QUIET_CYCLES(QC), .TRAIN_CYCLES(TC), .RX_NEED(8), .TX_NEED(16),
        .LINK_ID(LID), .LANE_ID(NID)
    ) u_link_train_ctrl (
        .clk(clk), .rst(rst), .idle_exit(idle_exit), .det_done(det_done),
        .det_present(det_present), .rx_valid(rx_valid), .rx_kind(rx_kind),
        .rx_link(rx_link), .rx_lane(rx_lane), .tx_done(tx_done),
        .det_req(det_req), .tx_a_req(tx_a_req), .tx_b_req(tx_b_req),
        .tx_link(tx_link), .tx_lane(tx_lane), .ltssm_state(ltssm_state), .link_up(link_up)
    );

    task automatic check(input int req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input int req, input logic [2:0] st);
        check(req, "state", ltssm_state, st);
        check(req, "det_req", det_req, st == 3'd1);
        check(req, "tx_a_req", tx_a_req, st == 3'd2);
        check(req, "tx_b_req", tx_b_req, (st == 3'd3) || (st == 3'd4));
        check(req, "tx_link", tx_link, (st == 3'd4) ? LID : PAD);
        check(req, "tx_lane", tx_lane, (st == 3'd4) ? NID : PAD);
        check(req, "link_up", link_up, st == 3'd5);
    endtask

    task automatic run_step(input step_t s);
        for (int i = 0; i < int'(s.cnt); i++) begin
            case (s.op)
                OP_EXIT: idle_exit = 1'b1;
                OP_DET0: begin det_done = 1'b1; det_present = 1'b0; end
                OP_DET1: begin det_done = 1'b1; det_present = 1'b1; end
                OP_RX:   begin rx_valid = 1'b1; rx_kind = s.kind; rx_link = s.link; rx_lane = s.lane; end
                OP_TXD:  tx_done = 1'b1;
                OP_RST:  rst = 1'b1;
                default: ;
            endcase
            @(negedge clk);
            idle_exit = 0; det_done = 0; det_present = 0; rx_valid = 0; tx_done = 0;
            rx_link = PAD; rx_lane = PAD; rst = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: outputs while reset is held
        check_outputs(1, 3'd0);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NSTEP; k++) begin
            run_step(STEPS[k]);
            check_outputs(int'(STEPS[k].req), STEPS[k].exp);
        end
        // R10: training limit in state 3 as well
        run_step('{OP_WAIT, 8'd85, 1'b0, PAD, PAD, 3'd0, 4'd10});
        check_outputs(10, 3'd0);
        // R3: det_done ignored in polling state 2
        run_step('{OP_EXIT, 8'd1, 1'b0, PAD, PAD, 3'd1, 4'd2});
        run_step('{OP_DET1, 8'd1, 1'b0, PAD, PAD, 3'd2, 4'd4});
        run_step('{OP_DET0, 8'd1, 1'b0, PAD, PAD, 3'd2, 4'd3});
        check_outputs(3, 3'd2);
        // R1: reset in the middle of training returns to quiet
        rst = 1'b1;
        @(negedge clk);
        check_outputs(1, 3'd0);
        rst = 1'b0;
        @(negedge clk);
        check_outputs(1, 3'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule